// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every received frame, whether the frame is kept or dropped based on its 48-bit destination address alone. A receive front end presents the address with a one-cycle valid strobe. The block compares it with the programmed station address and detects the broadcast address and the group (multicast) bit. It also hashes the address into an index that picks one bit of a 64-bit multicast filter.

A two-bit filter mode taken from the MAC control word selects one of four acceptance policies. They range from station-only, through hashed multicast and all-multicast, to promiscuous. One cycle after the strobe the block presents three things together with a done pulse: the accept decision, a status word carrying the individual match flags at fixed positions for the receive status vector, and an updated copy of the selected hash bit. The status word is merged into a wider receive status vector downstream.

Top module: `rx_da_filter`

## Requirements
- R1: While rst_ni is low and after its release, done_o, accept_o, rx_status_o and hash_bit_o are all 0 until the first strobe.
- R2: A strobe on da_valid_i sampled at a clock edge produces done_o high for exactly the following cycle. accept_o and rx_status_o change only after a strobe and hold their values otherwise. Strobes on consecutive cycles each give their own result.
- R3: Mode 00 (ctrl_word_i bits 6:5) accepts a frame only when the destination address equals station_addr_i.
- R4: Mode 01 accepts on a station match, on the broadcast address, or when the multicast filter match flag is set.
- R5: Mode 10 accepts on a station match, on the broadcast address, or on any multicast address.
- R6: Mode 11 accepts every frame.
- R7: rx_status_o bit 26 is the station match flag: destination address equal to station_addr_i over all 48 bits.
- R8: The first address octet is da_i[7:0], and its bit 0 (da_i[0]) marks a multicast address; that flag is reported at rx_status_o bit 19. An all-ones address is broadcast: it sets bit 20 and also sets bit 19.
- R9: The hash index is found as follows. A 32-bit register starts at all ones. It shifts in da_i[0] through da_i[47] one bit at a time, in that order, as a reflected CRC-32 with polynomial 0xEDB88320. The index is bits 31:26 of the bitwise complement of the final register. rx_status_o bit 25 is set when the address is multicast and hash_filter_i at that index is 1.
- R10: A strobe taken while rx_dma_en_i is 1 loads hash_bit_o with hash_filter_i at the hash index. A strobe taken while rx_dma_en_i is 0 leaves hash_bit_o unchanged.
- R11: Bits of ctrl_word_i other than 6:5 have no effect on accept_o or rx_status_o.
- R12: All rx_status_o bits other than 26, 25, 20 and 19 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| da_valid_i | input | 1 | Destination address strobe, one cycle per frame |
| da_i | input | 48 | Destination address, first octet in bits 7:0 |
| ctrl_word_i | input | 32 | MAC control word; filter mode in bits 6:5 |
| station_addr_i | input | 48 | Station address |
| hash_filter_i | input | 64 | Multicast hash filter |
| rx_dma_en_i | input | 1 | Receive DMA enabled; gates the hash bit update |
| done_o | output | 1 | Result valid pulse |
| accept_o | output | 1 | Frame accepted |
| rx_status_o | output | 32 | Match flags at bits 26, 25, 20, 19 |
| hash_bit_o | output | 1 | Latched selected hash filter bit |

## Verification
A broadcast frame raises the broadcast flag and the multicast flag in the same result word. Its hash can also hit the filter, so three flags and the mode-dependent decision resolve from one strobe. The bench provokes this by sending the all-ones address under every mode, with the filter both empty and full. In the same strobe cycle the hash bit update either fires or stays frozen, depending on the DMA enable. The bench toggles that enable across back-to-back strobes with changing filters. A behavioural reference computes every flag, the decision and the latched bit from the requirements, and the bench compares them on every clock.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;
  typedef enum logic [1:0] {
    FLT_OWN     = 2'b00,
    FLT_HASH    = 2'b01,
    FLT_ALLMC   = 2'b10,
    FLT_PROMISC = 2'b11
  } flt_mode_e;

  localparam int MODE_LSB = 5;
  localparam int ST_PHYS  = 26;
  localparam int ST_HASH  = 25;
  localparam int ST_BCAST = 20;
  localparam int ST_MCAST = 19;

  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef struct packed {
    logic phys;
    logic hash;
    logic bcast;
    logic mcast;
  } da_flags_t;
endpackage

// File: rtl/rx_da_hash.sv
module rx_da_hash #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  import rx_da_filter_pkg::*;

  logic [31:0] crc_q;

  // serial reflected CRC, LSB of first octet first
  always_comb begin
    logic [31:0] r;
    logic        fb;
    r = '1;
    for (int i = 0; i < ADDR_W; i++) begin
      fb = r[0] ^ addr_i[i];
      r  = {1'b0, r[31:1]} ^ (fb ? CRC_POLY : 32'h0);
    end
    crc_q = ~r;
  end

  assign idx_o = crc_q[31 -: IDX_W];
endmodule

// File: rtl/rx_da_classify.sv
module rx_da_classify #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 6,
  localparam int FILT_W = 1 << IDX_W
) (
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [ADDR_W-1:0]                 station_i,
  input  logic [FILT_W-1:0]                 filter_i,
  output rx_da_filter_pkg::da_flags_t       flags_o,
  output logic                              hash_sel_o
);
  logic [IDX_W-1:0] idx;

  rx_da_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr_i (addr_i),
    .idx_o  (idx)
  );

  assign hash_sel_o    = filter_i[idx];
  assign flags_o.phys  = (addr_i == station_i);
  assign flags_o.bcast = &addr_i;
  assign flags_o.mcast = addr_i[0];
  assign flags_o.hash  = addr_i[0] & hash_sel_o;
endmodule

// File: rtl/rx_da_decide.sv
module rx_da_decide (
  input  rx_da_filter_pkg::flt_mode_e mode_i,
  input  rx_da_filter_pkg::da_flags_t flags_i,
  output logic                        accept_o
);
  import rx_da_filter_pkg::*;

  always_comb begin
    unique case (mode_i)
      FLT_OWN:     accept_o = flags_i.phys;
      FLT_HASH:    accept_o = flags_i.phys | flags_i.bcast | flags_i.hash;
      FLT_ALLMC:   accept_o = flags_i.phys | flags_i.bcast | flags_i.mcast;
      FLT_PROMISC: accept_o = 1'b1;
      default:     accept_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter #(
  parameter int ADDR_W   = 48,
  parameter int IDX_W    = 6,
  parameter int CTRL_W   = 32,
  parameter int STATUS_W = 32,
  localparam int FILT_W  = 1 << IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                da_valid_i,
  input  logic [ADDR_W-1:0]   da_i,
  input  logic [CTRL_W-1:0]   ctrl_word_i,
  input  logic [ADDR_W-1:0]   station_addr_i,
  input  logic [FILT_W-1:0]   hash_filter_i,
  input  logic                rx_dma_en_i,
  output logic                done_o,
  output logic                accept_o,
  output logic [STATUS_W-1:0] rx_status_o,
  output logic                hash_bit_o
);
  import rx_da_filter_pkg::*;

  flt_mode_e           mode;
  da_flags_t           flags;
  logic                hash_sel;
  logic                accept_d;
  logic [STATUS_W-1:0] status_d;

  assign mode = flt_mode_e'(ctrl_word_i[MODE_LSB +: 2]);

  rx_da_classify #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_class (
    .addr_i     (da_i),
    .station_i  (station_addr_i),
    .filter_i   (hash_filter_i),
    .flags_o    (flags),
    .hash_sel_o (hash_sel)
  );

  rx_da_decide u_decide (
    .mode_i   (mode),
    .flags_i  (flags),
    .accept_o (accept_d)
  );

  always_comb begin
    status_d           = '0;
    status_d[ST_PHYS]  = flags.phys;
    status_d[ST_HASH]  = flags.hash;
    status_d[ST_BCAST] = flags.bcast;
    status_d[ST_MCAST] = flags.mcast | flags.bcast;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      accept_o    <= 1'b0;
      rx_status_o <= '0;
      hash_bit_o  <= 1'b0;
    end else begin
      done_o <= da_valid_i;
      if (da_valid_i) begin
        accept_o    <= accept_d;
        rx_status_o <= status_d;
        if (rx_dma_en_i) hash_bit_o <= hash_sel;
      end
    end
  end

  assert_done_follows_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(da_valid_i));
  assert_result_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(da_valid_i) |-> ($stable(accept_o) && $stable(rx_status_o)));
  assert_own_mode_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(ctrl_word_i[MODE_LSB +: 2]) == 2'b00) |-> (accept_o == rx_status_o[ST_PHYS]));
  assert_promisc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(ctrl_word_i[MODE_LSB +: 2]) == 2'b11) |-> accept_o);
  assert_bcast_is_mcast_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_status_o[ST_BCAST] |-> rx_status_o[ST_MCAST]);
  assert_hash_needs_mcast_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_status_o[ST_HASH] |-> rx_status_o[ST_MCAST]);
  assert_hash_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(da_valid_i && rx_dma_en_i) |-> $stable(hash_bit_o));
endmodule

// File: tb/sim_rx_da_filter.sv
module sim_rx_da_filter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        da_valid_i = 1'b0;
  logic [47:0] da_i = '0;
  logic [31:0] ctrl_word_i = '0;
  logic [47:0] station_addr_i = '0;
  logic [63:0] hash_filter_i = '0;
  logic        rx_dma_en_i = 1'b0;
  logic        done_o, accept_o, hash_bit_o;
  logic [31:0] rx_status_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  bit r11_phase = 0;

  always #10 clk = ~clk;

  rx_da_filter u0 (
    .clk_i(clk), .rst_ni(rst_ni), .da_valid_i(da_valid_i), .da_i(da_i),
    .ctrl_word_i(ctrl_word_i), .station_addr_i(station_addr_i),
    .hash_filter_i(hash_filter_i), .rx_dma_en_i(rx_dma_en_i),
    .done_o(done_o), .accept_o(accept_o), .rx_status_o(rx_status_o),
    .hash_bit_o(hash_bit_o)
  );

  function automatic int ref_index(logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      if (r[0] != a[i]) r = (r >> 1) ^ 32'hEDB8_8320;
      else r = r >> 1;
    end
    r = ~r;
    return int'(r[31:26]);
  endfunction

  // reference model
  bit       e_done, e_acc, e_hash;
  bit [3:0] e_flags; // phys, hash, bcast, mcast
  int       e_mode;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      e_done = 0; e_acc = 0; e_hash = 0; e_flags = '0; e_mode = 0;
    end else begin
      e_done = da_valid_i;
      if (da_valid_i) begin
        bit ph, bc, mc, hh, sel;
        int m;
        ph  = (da_i == station_addr_i);
        bc  = (da_i == 48'hFFFF_FFFF_FFFF);
        mc  = da_i[0];
        sel = hash_filter_i[ref_index(da_i)];
        hh  = mc && sel;
        m   = ctrl_word_i[6] * 2 + ctrl_word_i[5];
        e_mode = m;
        if (m == 0) e_acc = ph;
        else if (m == 1) e_acc = ph || bc || hh;
        else if (m == 2) e_acc = ph || bc || mc;
        else e_acc = 1;
        e_flags = {ph, hh, bc, mc};
        if (rx_dma_en_i) e_hash = sel;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_ni) begin
        chk("R1", {accept_o, done_o, hash_bit_o}, 32'h0);
        chk("R1", rx_status_o, 32'h0);
      end else begin
        string acc_tag;
        acc_tag = r11_phase ? "R11" : (e_mode == 0) ? "R3" : (e_mode == 1) ? "R4" :
                  (e_mode == 2) ? "R5" : "R6";
        chk("R2", {31'h0, done_o}, {31'h0, e_done});
        chk(acc_tag, {31'h0, accept_o}, {31'h0, e_acc});
        chk("R7", {31'h0, rx_status_o[26]}, {31'h0, e_flags[3]});
        chk("R9", {31'h0, rx_status_o[25]}, {31'h0, e_flags[2]});
        chk("R8", {30'h0, rx_status_o[20], rx_status_o[19]},
            {30'h0, e_flags[1], e_flags[0] | e_flags[1]});
        chk("R12", rx_status_o & ~32'h0618_0000, 32'h0);
        chk("R10", {31'h0, hash_bit_o}, {31'h0, e_hash});
      end
    end
  end

  task automatic frame(logic [47:0] da, int mode, logic [63:0] flt, bit dma);
    da_i = da;
    ctrl_word_i[6:5] = 2'(mode);
    hash_filter_i = flt;
    rx_dma_en_i = dma;
    da_valid_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    da_valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  localparam logic [47:0] STA = 48'h5544_3322_1102;
  localparam logic [47:0] UNI = 48'h0123_4567_890C;
  localparam logic [47:0] MC  = 48'h0100_005E_0001;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #200_000_000;
    $display("FAIL R2 watchdog expired");
    miscompares++;
    finish_run();
  end

  initial begin
    logic [47:0] lf;
    logic [63:0] hit_mc, hit_bc;
    station_addr_i = STA;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle(2);
    hit_mc = 64'h1 << ref_index(MC);
    hit_bc = 64'h1 << ref_index(BC);
    for (int m = 0; m < 4; m++) begin
      frame(STA, m, 64'h0, 1);
      idle(1);
      frame(UNI, m, 64'hFFFF_FFFF_FFFF_FFFF, 1);
      frame(BC, m, 64'h0, 0);
      frame(BC, m, hit_bc, 1);
      frame(MC, m, hit_mc, 1);
      idle(2);
      frame(MC, m, ~hit_mc, 0);
      frame(MC, m, ~hit_mc, 1);
      idle(1);
    end
    // station programmed to a multicast address, hashed mode
    station_addr_i = MC;
    frame(MC, 1, 64'h0, 1);
    frame(MC, 0, 64'h0, 0);
    station_addr_i = STA;
    idle(2);
    // pseudo-random with unrelated control bits toggling
    r11_phase = 1;
    lf = 48'hACE1_2345_6789;
    for (int i = 0; i < 120; i++) begin
      lf = {lf[46:0], lf[47] ^ lf[46] ^ lf[20] ^ lf[19]};
      ctrl_word_i = {lf[31:7], 2'b00, lf[4:0]};
      frame((i % 7 == 0) ? STA : (i % 11 == 0) ? BC : lf, i % 4,
            {lf[31:0], lf[47:16]}, lf[3]);
      if (i % 5 == 0) idle(1);
    end
    r11_phase = 0;
    idle(3);
    finish_run();
  end
endmodule